// File: doc/BRIEF.md
# Branch Clock Gate Controller

This block passes or withholds a free-running root clock to a single peripheral. Software turns the branch on in one of two ways. It can set a local enable bit in the branch control word. It can also set this branch's bit in a vote word, which several masters share. The branch runs whenever either source asks for it. The enable request crosses into the root-clock domain through a synchronizer. It then reaches the output through a flop clocked on the falling root edge. The output therefore only switches while the root clock is low, and no shortened pulse can reach the peripheral.

The real gate state is synchronized back into the bus domain and shown as a read-only "clock off" flag in bit 31 of the control word. After enabling, software polls that flag until it reads zero. The flag cannot clear while the root clock is stopped. A separate reset word holds the peripheral in reset for as long as its bit 0 is set.

Register selection (`reg_addr`): 0 is the branch control word, 1 is the vote word, 2 is the peripheral reset word, and 3 is unused.

Top module: `brgate_ctrl`

## Requirements
- R1: Synchronous reset clears the local enable, the whole vote word and the reset bit. During reset and right after it, the control word reads 0x8000_0000 (clock off) and `gated_clk` stays low.
- R2: Control-word bit 0 is the local enable and reads back as written. Bit 31 is read-only: writing it has no effect on the branch.
- R3: Setting vote-word bit `VOTE_BIT` (default 10) turns the branch on when the local enable is clear. Any other vote bit has no effect on this branch. The vote word reads back all 32 bits as written.
- R4: The effective enable is the OR of the local enable and the vote bit. Clearing one source while the other is still set keeps the clock running.
- R5: Control-word bit 31 reads 1 while the branch is stopped. After the effective enable rises, it still reads 1 in the cycle after the write. It clears within 12 bus-clock cycles.
- R6: Every high pulse on `gated_clk` is a full root-clock high phase. No runt pulse appears, even when an enable is withdrawn while it is still crossing into the root domain.
- R7: When the effective enable falls, the clock stops after the current high phase completes. Bit 31 then returns to 1, and no further edges appear on `gated_clk`.
- R8: While the root clock is not toggling, bit 31 stays 1 even if the branch is enabled. It clears once the root clock resumes.
- R9: Reset-word bit 0 drives `periph_rst` starting one cycle after the write, and reads back.
- R10: Control-word bits 30:1, reset-word bits 31:1 and register 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus/register clock |
| rst | input | 1 | Synchronous active-high reset |
| root_clk | input | 1 | Root clock to be gated |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| gated_clk | output | 1 | Branch clock delivered to the peripheral |
| periph_rst | output | 1 | Peripheral reset, high while held |

## Verification
Two functions can fall in the same cycle. The first is a request withdrawal: the effective enable falls. The second is the status path: the gate turns on in the root domain, and the off flag is about to clear. The bench provokes the collision by writing the enable and clearing it on the very next bus cycle, so the request is still inside the synchronizer when it is withdrawn. It then judges the outcome in two ways. A pulse-width monitor must see no high pulse shorter than a root half period. The off flag must settle back to 1 with the output quiet.

// File: rtl/brgate_pkg.sv
package brgate_pkg;

    localparam int unsigned REG_W       = 32;
    localparam int unsigned CTL_EN_BIT  = 0;
    localparam int unsigned CTL_OFF_BIT = 31;
    localparam int unsigned BRST_BIT    = 0;

    typedef enum logic [1:0] {
        SEL_CTL   = 2'd0,
        SEL_VOTE  = 2'd1,
        SEL_BRST  = 2'd2,
        SEL_SPARE = 2'd3
    } brg_sel_e;

    typedef struct packed {
        logic             en;
        logic [REG_W-1:0] vote;
        logic             brst;
    } brg_regs_t;

    function automatic logic [REG_W-1:0] ctl_word(input logic en, input logic off);
        logic [REG_W-1:0] w;
        w              = '0;
        w[CTL_EN_BIT]  = en;
        w[CTL_OFF_BIT] = off;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] brst_word(input logic b);
        logic [REG_W-1:0] w;
        w           = '0;
        w[BRST_BIT] = b;
        return w;
    endfunction

endpackage

// File: rtl/brg_sync.sv
module brg_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= {N{RST_VAL}};
        else     sr <= {sr[N-2:0], d};
    end

    assign q = sr[N-1];
endmodule

// File: rtl/brg_regs.sv
module brg_regs
    import brgate_pkg::*;
#(
    parameter int unsigned VOTE_BIT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  brg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             off_flag,
    output logic [REG_W-1:0] rdata,
    output logic             eff_en,
    output logic             periph_rst
);
    brg_regs_t regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_CTL:  regs_q.en   <= wdata[CTL_EN_BIT];
                SEL_VOTE: regs_q.vote <= wdata;
                SEL_BRST: regs_q.brst <= wdata[BRST_BIT];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_CTL:  rdata = ctl_word(regs_q.en, off_flag);
            SEL_VOTE: rdata = regs_q.vote;
            SEL_BRST: rdata = brst_word(regs_q.brst);
            default:  rdata = '0;
        endcase
    end

    assign eff_en     = regs_q.en | regs_q.vote[VOTE_BIT];
    assign periph_rst = regs_q.brst;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!eff_en && !periph_rst));

    p_rst_follow_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_BRST) |=> (periph_rst == $past(wdata[BRST_BIT])));

    p_vote_wake_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_VOTE && wdata[VOTE_BIT]) |=> eff_en);

    p_local_wake_r4: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_CTL && wdata[CTL_EN_BIT]) |=> eff_en);
endmodule

// File: rtl/brg_gate_cell.sv
module brg_gate_cell #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic root_clk,
    input  logic rst,
    input  logic eff_en,
    output logic gate_q,
    output logic gated_clk
);
    logic root_rst;
    logic en_root;

    brg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rst_sync (
        .clk (root_clk),
        .rst (1'b0),
        .d   (rst),
        .q   (root_rst)
    );

    brg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk (root_clk),
        .rst (root_rst),
        .d   (eff_en),
        .q   (en_root)
    );

    // Gate state may change only while root_clk is low.
    always_ff @(negedge root_clk) begin
        if (root_rst) gate_q <= 1'b0;
        else          gate_q <= en_root;
    end

    assign gated_clk = root_clk & gate_q;

    p_gate_tracks_sync_r7: assert property (@(negedge root_clk) disable iff (root_rst)
        $fell(en_root) |=> !gate_q);
endmodule

// File: rtl/brgate_ctrl.sv
module brgate_ctrl
    import brgate_pkg::*;
#(
    parameter int unsigned VOTE_BIT    = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              root_clk,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              gated_clk,
    output logic              periph_rst
);
    logic eff_en;
    logic gate_q;
    logic running;
    logic off_flag;

    brg_regs #(.VOTE_BIT(VOTE_BIT)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (reg_wr),
        .sel        (brg_sel_e'(reg_addr)),
        .wdata      (reg_wdata),
        .off_flag   (off_flag),
        .rdata      (reg_rdata),
        .eff_en     (eff_en),
        .periph_rst (periph_rst)
    );

    brg_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .root_clk  (root_clk),
        .rst       (rst),
        .eff_en    (eff_en),
        .gate_q    (gate_q),
        .gated_clk (gated_clk)
    );

    brg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_status_sync (
        .clk (clk),
        .rst (rst),
        .d   (gate_q),
        .q   (running)
    );

    assign off_flag = ~running;

    p_on_lag_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(eff_en) && off_flag) |=> off_flag);

    p_off_lag_r7: assert property (@(posedge clk) disable iff (rst)
        ($fell(eff_en) && !off_flag) |=> !off_flag);
endmodule

// File: tb/tb_brgate_ctrl.sv
module tb_brgate_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        root_clk = 1'b0;
    logic        root_run = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        gated_clk;
    logic        periph_rst;

    int n_chk = 0;
    int n_bad = 0;
    int g_edges = 0;
    int runts = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;
    realtime t_rise = 0.0;

    brgate_ctrl dut (
        .clk(clk), .rst(rst), .root_clk(root_clk), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gated_clk(gated_clk), .periph_rst(periph_rst)
    );

    always #2 clk = ~clk;
    always begin
        #5;
        if (root_run) root_clk = ~root_clk;
    end

    always @(posedge gated_clk) begin
        t_rise = $realtime;
        if (mon_on) g_edges++;
    end
    always @(negedge gated_clk) begin
        if (mon_on && ($realtime - t_rise) < 4.9) runts++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic count_edges(output int n);
        g_edges = 0;
        repeat (40) @(negedge clk);
        n = g_edges;
    endtask

    // {addr, wdata, expected control word, expected running}
    localparam int NV = 7;
    localparam logic [66:0] VEC [NV] = '{
        {2'd0, 32'h0000_0001, 32'h0000_0001, 1'b1},  // R2 local enable
        {2'd0, 32'h0000_0000, 32'h8000_0000, 1'b0},  // R7 stop
        {2'd1, 32'h0000_0400, 32'h0000_0000, 1'b1},  // R3 vote bit 10
        {2'd0, 32'h0000_0001, 32'h0000_0001, 1'b1},  // R4 both set
        {2'd1, 32'h0000_0000, 32'h0000_0001, 1'b1},  // R4 vote cleared, local holds
        {2'd0, 32'h8000_0000, 32'h8000_0000, 1'b0},  // R2 bit 31 write ignored
        {2'd1, 32'h0000_0800, 32'h8000_0000, 1'b0}   // R3 other vote bit ignored
    };

    initial begin
        logic [31:0] v;
        int n;
        bit seen;
        repeat (12) @(negedge clk);
        // R1 during reset
        rd(2'd0, v); check("R1 ctl in reset", v, 32'h8000_0000);
        check("R1 gated low", {31'd0, gated_clk}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;
        rd(2'd0, v); check("R1 ctl after reset", v, 32'h8000_0000);
        rd(2'd1, v); check("R1 vote after reset", v, 32'h0);
        rd(2'd2, v); check("R1 brst after reset", v, 32'h0);
        check("R1 periph_rst", {31'd0, periph_rst}, 32'd0);
        rd(2'd3, v); check("R10 spare reads zero", v, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][66:65], VEC[i][64:33]);
            repeat (20) @(negedge clk);
            rd(2'd0, v); check($sformatf("vector %0d ctl (R2/R3/R4/R5)", i), v, VEC[i][32:1]);
            count_edges(n);
            check($sformatf("vector %0d running (R3/R4/R7)", i),
                  {31'd0, (n >= 14)}, {31'd0, VEC[i][0]});
            if (!VEC[i][0]) check($sformatf("vector %0d no edges R7", i), n, 0);
        end
        rd(2'd1, v); check("R3 vote readback", v, 32'h0000_0800);
        wr(2'd1, 32'h0);

        // R5 lag: still off the cycle after the write, clears within 12 cycles
        wr(2'd0, 32'h1);
        rd(2'd0, v); check("R5 off still set after write", v, 32'h8000_0001);
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            rd(2'd0, v);
            if (v[31] == 1'b0) seen = 1'b1;
        end
        check("R5 off clears within 12", {31'd0, seen}, 32'd1);

        // R7 stop, R6 runts
        wr(2'd0, 32'h0);
        repeat (15) @(negedge clk);
        rd(2'd0, v); check("R7 off after stop", v, 32'h8000_0000);
        count_edges(n); check("R7 quiet after stop", n, 0);

        // Concurrent: enable withdrawn while crossing (R6)
        for (int k = 0; k < 4; k++) begin
            wr(2'd0, 32'h1);
            repeat (k) @(negedge clk);
            wr(2'd0, 32'h0);
            repeat (20) @(negedge clk);
        end
        rd(2'd0, v); check("R6 off after withdrawn enable", v, 32'h8000_0000);
        check("R6 no runt pulses", runts, 0);

        // R8 root stopped
        root_run = 1'b0;
        repeat (4) @(negedge clk);
        wr(2'd0, 32'h1);
        repeat (30) @(negedge clk);
        rd(2'd0, v); check("R8 off stays set, root stopped", v, 32'h8000_0001);
        count_edges(n); check("R8 no edges, root stopped", n, 0);
        root_run = 1'b1;
        repeat (15) @(negedge clk);
        rd(2'd0, v); check("R8 off clears after root resumes", v, 32'h0000_0001);
        wr(2'd0, 32'h0);
        repeat (15) @(negedge clk);

        // R9 peripheral reset
        wr(2'd2, 32'hFFFF_FFFF);
        check("R9 periph_rst set", {31'd0, periph_rst}, 32'd1);
        rd(2'd2, v); check("R9/R10 brst readback", v, 32'h1);
        wr(2'd2, 32'h0);
        check("R9 periph_rst released", {31'd0, periph_rst}, 32'd0);
        check("R6 final runt count", runts, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule